// File: doc/BRIEF.md
# Microcoded Instruction Step Sequencer

This block is the control unit of a small 16-bit microcoded processor. Each clock it looks at the opcode held in the instruction register and at its own three-bit step count, and it emits one control word. That word enables one bus driver and the register loads for the cycle. It also carries the ALU control bits, a program-counter increment request and a jump decision. The microcode is a synthesizable case statement addressed by opcode and step. It holds only on/off control bits and no numeric literals. Every value an instruction needs comes from memory, from the instruction word's low byte, or from the few constants the ALU can make by itself.

Every instruction lasts exactly eight clocks. The first two are a common fetch and the remaining six do the instruction's own work. The block also forms the immediate from the instruction word's low byte in one of two ways. In the high-page form the upper byte is forced to ones, which addresses the top 256 words of memory. In the small-constant form the upper byte is forced to zeros. The datapath registers, memory, ALU arithmetic and program counter live outside this block.

Top module: `scu_sequencer`

## Requirements
- R1: The step count runs 0,1,...,7 and then wraps to 0, advancing by one on every clock. A synchronous active-high reset forces it to 0, including in the middle of an instruction, so that execution resumes with a fetch.
- R2: For every opcode, step 0 drives the program counter and loads the address register (drv_o=6'b000100, load_o=5'b00001), and step 1 drives memory and loads the instruction register (drv_o=6'b000010, load_o=5'b10000). alu_o is 0 in both steps and no increment or jump is requested. The instruction register is never loaded in any other step.
- R3: At most one driver bit is set in any step. The driver bits are 0 ALU, 1 memory, 2 program counter, 3 X register, 4 low-byte immediate and 5 high-page immediate. The load bits are 0 address, 1 memory, 2 X, 3 Y and 4 instruction. The ALU bits, from 5 down to 0, are enable-X, enable-Y, invert-X, invert-Y, add (else AND) and invert-out. The ALU codes are add 110010, AND 110000, OR 111101, NAND 110001, minus-one 000001, minus-two 001110 and Y-minus-one 011010.
- R4: While the high-page driver is enabled, bus_imm_o equals {8'hFF, ir_i[7:0]}.
- R5: While the low-byte driver is enabled, bus_imm_o equals {8'h00, ir_i[7:0]}. While neither immediate driver is enabled, bus_imm_o is 0.
- R6: jmp_o is set when the current step's jump-if-not-zero bit is set and flag_z_i is 0, or when its jump-if-zero bit is set and flag_z_i is 1. While jmp_o is set, pc_inc_o is 0.
- R7: Data opcodes (ir_i[15:8]) use steps 2-3 and leave steps 4-7 empty. Opcode 0x01 loads the low byte into X: step 2 low-byte driver and X load. Opcode 0x02 adds the low byte to X: step 2 low-byte driver and Y load, then step 3 ALU add and X load. Opcode 0x03 loads X from a high-page word: step 2 high-page driver and address load, then step 3 memory driver and X load. Opcode 0x04 stores X to a high-page word: step 2 high-page driver and address load, then step 3 X driver and memory load.
- R8: Opcode 0x05 pushes X through the pointer at the top word and runs six steps. Step 2 is ALU minus-one with address load. Step 3 is memory driver with Y load. Step 4 is memory driver with address load. Step 5 is X driver with memory load. Step 6 is ALU minus-one with address load. Step 7 is ALU Y-minus-one with memory load. Opcode 0x06 computes X xor Y in steps 2-6, using the word just below the top as scratch. Step 2 is ALU minus-two with address load. Step 3 is ALU OR with memory load. Step 4 is ALU NAND with Y load. Step 5 is memory driver with X load. Step 6 is ALU AND with X load.
- R9: Opcode 0x07 tests a high-page word against the following mask word and skips the next word when the result is zero. Step 2 is high-page driver with address load. Step 3 is memory driver with X load. Step 4 is program-counter driver with address load. Step 5 is memory driver with Y load and increment. Step 6 is ALU AND with no load. Step 7 is program-counter driver with increment and jump-if-not-zero. Opcodes 0x08 and 0x09 are conditional jumps to the following word. Step 2 is program-counter driver with address load. Step 3 is memory driver with increment and jump-if-not-zero (0x08) or jump-if-zero (0x09).
- R10: Opcode 0x00 and every opcode without microcode produce an all-zero control word in steps 2 to 7. Only ir_i[15:8] selects the microcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the step count |
| ir_i | input | 16 | Instruction register contents: opcode in 15:8, immediate in 7:0 |
| flag_z_i | input | 1 | Zero flag from the flags register |
| step_o | output | 3 | Current step within the instruction |
| drv_o | output | 6 | One-hot bus driver enables |
| load_o | output | 5 | Register and memory load enables |
| alu_o | output | 6 | ALU control bits |
| pc_inc_o | output | 1 | Program-counter increment, withheld when a jump is taken |
| jmp_o | output | 1 | Program-counter jump (load from bus) |
| bus_imm_o | output | 16 | Immediate value formed from the instruction word |

## Verification
Every defined opcode is run through all eight steps, together with opcode 0x00 and two opcodes that have no microcode. This separates the shared fetch steps from each instruction's own steps and shows that empty steps stay empty. Each instruction runs once with the zero flag clear and once with it set. Only the jump-bearing opcodes should change behaviour between the two runs, and the runs show the increment being withheld exactly when a jump is taken. The low instruction byte changes with the opcode, so the two immediate forms can be told apart from a stale or fixed value. A reset in the middle of an instruction checks that the sequence restarts at the fetch.

// File: rtl/scu_pkg.sv
package scu_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned IMM_W  = 8;
    localparam int unsigned OPC_W  = 8;
    localparam int unsigned STEP_W = 3;

    // Bus driver enables; at most one may be set in a step.
    typedef struct packed {
        logic ioh;  // low byte with upper bits forced high
        logic iol;  // low byte with upper bits forced low
        logic xo;
        logic po;
        logic mo;
        logic ao;
    } drv_t;

    typedef struct packed {
        logic ii;
        logic yi;
        logic xi;
        logic mi;
        logic ai;
    } ld_t;

    typedef struct packed {
        logic ex;
        logic ey;
        logic nx;
        logic ny;
        logic f;
        logic no;
    } alu_t;

    typedef struct packed {
        drv_t drv;
        ld_t  ld;
        alu_t alu;
        logic pc_inc;
        logic jz;
        logic jnz;
    } ctrl_t;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 8'h00,
        OP_LDXI  = 8'h01,
        OP_ADDXI = 8'h02,
        OP_LDXR  = 8'h03,
        OP_STXR  = 8'h04,
        OP_PUSHX = 8'h05,
        OP_XORY  = 8'h06,
        OP_TBSZ  = 8'h07,
        OP_JNZ   = 8'h08,
        OP_JZ    = 8'h09
    } opc_e;

    localparam drv_t D_NONE = 6'b000000;
    localparam drv_t D_AO   = 6'b000001;
    localparam drv_t D_MO   = 6'b000010;
    localparam drv_t D_PO   = 6'b000100;
    localparam drv_t D_XO   = 6'b001000;
    localparam drv_t D_IOL  = 6'b010000;
    localparam drv_t D_IOH  = 6'b100000;

    localparam ld_t L_NONE = 5'b00000;
    localparam ld_t L_AI   = 5'b00001;
    localparam ld_t L_MI   = 5'b00010;
    localparam ld_t L_XI   = 5'b00100;
    localparam ld_t L_YI   = 5'b01000;
    localparam ld_t L_II   = 5'b10000;

    // ALU selections expressed only as control bits, never as literals
    localparam alu_t A_NONE = 6'b000000;
    localparam alu_t A_ADD  = 6'b110010;
    localparam alu_t A_AND  = 6'b110000;
    localparam alu_t A_OR   = 6'b111101;
    localparam alu_t A_NAND = 6'b110001;
    localparam alu_t A_M1   = 6'b000001;
    localparam alu_t A_M2   = 6'b001110;
    localparam alu_t A_YM1  = 6'b011010;

    function automatic ctrl_t uop(input drv_t d, input ld_t l, input alu_t a,
                                  input logic inc, input logic jz, input logic jnz);
        ctrl_t c;
        c.drv    = d;
        c.ld     = l;
        c.alu    = a;
        c.pc_inc = inc;
        c.jz     = jz;
        c.jnz    = jnz;
        return c;
    endfunction

endpackage

// File: rtl/scu_step_counter.sv
module scu_step_counter #(
    parameter int unsigned STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STEP_W-1:0] step_o
);

    // Wraps naturally at 2**STEP_W.
    always_ff @(posedge clk) begin
        if (rst) begin
            step_o <= '0;
        end else begin
            step_o <= step_o + 1'b1;
        end
    end

endmodule

// File: rtl/scu_microcode_rom.sv
module scu_microcode_rom
    import scu_pkg::*;
(
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [STEP_W-1:0] step_i,
    output ctrl_t             ctrl_o
);

    ctrl_t body;

    // Instruction-specific steps 2..7
    always_comb begin
        body = '0;
        case (opc_i)
            OP_LDXI: begin
                if (step_i == 3'd2) body = uop(D_IOL, L_XI, A_NONE, 1'b0, 1'b0, 1'b0);
            end
            OP_ADDXI: begin
                case (step_i)
                    3'd2:    body = uop(D_IOL, L_YI, A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_AO,  L_XI, A_ADD,  1'b0, 1'b0, 1'b0);
                    default: body = '0;
                endcase
            end
            OP_LDXR: begin
                case (step_i)
                    3'd2:    body = uop(D_IOH, L_AI, A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_MO,  L_XI, A_NONE, 1'b0, 1'b0, 1'b0);
                    default: body = '0;
                endcase
            end
            OP_STXR: begin
                case (step_i)
                    3'd2:    body = uop(D_IOH, L_AI, A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_XO,  L_MI, A_NONE, 1'b0, 1'b0, 1'b0);
                    default: body = '0;
                endcase
            end
            OP_PUSHX: begin
                case (step_i)
                    3'd2:    body = uop(D_AO, L_AI, A_M1,   1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_MO, L_YI, A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd4:    body = uop(D_MO, L_AI, A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd5:    body = uop(D_XO, L_MI, A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd6:    body = uop(D_AO, L_AI, A_M1,   1'b0, 1'b0, 1'b0);
                    3'd7:    body = uop(D_AO, L_MI, A_YM1,  1'b0, 1'b0, 1'b0);
                    default: body = '0;
                endcase
            end
            OP_XORY: begin
                case (step_i)
                    3'd2:    body = uop(D_AO, L_AI, A_M2,   1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_AO, L_MI, A_OR,   1'b0, 1'b0, 1'b0);
                    3'd4:    body = uop(D_AO, L_YI, A_NAND, 1'b0, 1'b0, 1'b0);
                    3'd5:    body = uop(D_MO, L_XI, A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd6:    body = uop(D_AO, L_XI, A_AND,  1'b0, 1'b0, 1'b0);
                    default: body = '0;
                endcase
            end
            OP_TBSZ: begin
                case (step_i)
                    3'd2:    body = uop(D_IOH, L_AI,   A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_MO,  L_XI,   A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd4:    body = uop(D_PO,  L_AI,   A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd5:    body = uop(D_MO,  L_YI,   A_NONE, 1'b1, 1'b0, 1'b0);
                    3'd6:    body = uop(D_AO,  L_NONE, A_AND,  1'b0, 1'b0, 1'b0);
                    3'd7:    body = uop(D_PO,  L_NONE, A_NONE, 1'b1, 1'b0, 1'b1);
                    default: body = '0;
                endcase
            end
            OP_JNZ: begin
                case (step_i)
                    3'd2:    body = uop(D_PO, L_AI,   A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_MO, L_NONE, A_NONE, 1'b1, 1'b0, 1'b1);
                    default: body = '0;
                endcase
            end
            OP_JZ: begin
                case (step_i)
                    3'd2:    body = uop(D_PO, L_AI,   A_NONE, 1'b0, 1'b0, 1'b0);
                    3'd3:    body = uop(D_MO, L_NONE, A_NONE, 1'b1, 1'b1, 1'b0);
                    default: body = '0;
                endcase
            end
            default: body = '0;
        endcase
    end

    // Common fetch overrides steps 0 and 1
    always_comb begin
        case (step_i)
            3'd0:    ctrl_o = uop(D_PO, L_AI, A_NONE, 1'b0, 1'b0, 1'b0);
            3'd1:    ctrl_o = uop(D_MO, L_II, A_NONE, 1'b0, 1'b0, 1'b0);
            default: ctrl_o = body;
        endcase
    end

endmodule

// File: rtl/scu_bus_imm.sv
module scu_bus_imm #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned IMM_W  = 8
) (
    input  logic [WORD_W-1:0] ir_i,
    input  logic              sel_hi_i,
    input  logic              sel_lo_i,
    output logic [WORD_W-1:0] bus_o
);

    localparam int unsigned FILL_W = WORD_W - IMM_W;

    logic [IMM_W-1:0] low;
    assign low = ir_i[IMM_W-1:0];

    always_comb begin
        if (sel_hi_i) begin
            bus_o = {{FILL_W{1'b1}}, low};
        end else if (sel_lo_i) begin
            bus_o = {{FILL_W{1'b0}}, low};
        end else begin
            bus_o = '0;
        end
    end

endmodule

// File: rtl/scu_jump_unit.sv
module scu_jump_unit (
    input  logic jz_i,
    input  logic jnz_i,
    input  logic inc_i,
    input  logic flag_z_i,
    output logic jmp_o,
    output logic inc_o
);

    // A taken jump has priority over the increment request.
    always_comb begin
        jmp_o = (jnz_i & ~flag_z_i) | (jz_i & flag_z_i);
        inc_o = inc_i & ~jmp_o;
    end

endmodule

// File: rtl/scu_sequencer.sv
module scu_sequencer
    import scu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ir_i,
    input  logic              flag_z_i,
    output logic [STEP_W-1:0] step_o,
    output logic [5:0]        drv_o,
    output logic [4:0]        load_o,
    output logic [5:0]        alu_o,
    output logic              pc_inc_o,
    output logic              jmp_o,
    output logic [WORD_W-1:0] bus_imm_o
);

    ctrl_t            ctrl;
    logic [OPC_W-1:0] opc;

    assign opc = ir_i[WORD_W-1 -: OPC_W];

    scu_step_counter #(.STEP_W(STEP_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .step_o (step_o)
    );

    scu_microcode_rom u_rom (
        .opc_i  (opc),
        .step_i (step_o),
        .ctrl_o (ctrl)
    );

    scu_bus_imm #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_imm (
        .ir_i     (ir_i),
        .sel_hi_i (ctrl.drv.ioh),
        .sel_lo_i (ctrl.drv.iol),
        .bus_o    (bus_imm_o)
    );

    scu_jump_unit u_jmp (
        .jz_i     (ctrl.jz),
        .jnz_i    (ctrl.jnz),
        .inc_i    (ctrl.pc_inc),
        .flag_z_i (flag_z_i),
        .jmp_o    (jmp_o),
        .inc_o    (pc_inc_o)
    );

    assign drv_o  = ctrl.drv;
    assign load_o = ctrl.ld;
    assign alu_o  = ctrl.alu;

endmodule

// File: rtl/scu_sequencer_checker.sv
module scu_sequencer_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] ir_i,
    input logic [2:0]  step_o,
    input logic [5:0]  drv_o,
    input logic [4:0]  load_o,
    input logic [15:0] bus_imm_o
);

    assert_step_advance_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> step_o == 3'($past(step_o) + 3'd1));

    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
        step_o == 3'd0 |-> drv_o == 6'b000100 && load_o == 5'b00001);

    assert_fetch_ir_only_R2: assert property (@(posedge clk) disable iff (rst)
        load_o[4] |-> step_o == 3'd1 && drv_o == 6'b000010);

    assert_one_driver_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_o));

    assert_high_page_R4: assert property (@(posedge clk) disable iff (rst)
        drv_o[5] |-> bus_imm_o == {8'hFF, ir_i[7:0]});

    assert_low_imm_R5: assert property (@(posedge clk) disable iff (rst)
        drv_o[4] |-> bus_imm_o == {8'h00, ir_i[7:0]});

endmodule

bind scu_sequencer scu_sequencer_checker u_scu_chk (
    .clk       (clk),
    .rst       (rst),
    .ir_i      (ir_i),
    .step_o    (step_o),
    .drv_o     (drv_o),
    .load_o    (load_o),
    .bus_imm_o (bus_imm_o)
);

// File: tb/scu_sequencer_bench.sv
module scu_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ir_i = '0;
    logic        flag_z_i = 1'b0;
    logic [2:0]  step_o;
    logic [5:0]  drv_o;
    logic [4:0]  load_o;
    logic [5:0]  alu_o;
    logic        pc_inc_o;
    logic        jmp_o;
    logic [15:0] bus_imm_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scu_sequencer u_scu_sequencer (
        .clk(clk), .rst(rst), .ir_i(ir_i), .flag_z_i(flag_z_i),
        .step_o(step_o), .drv_o(drv_o), .load_o(load_o), .alu_o(alu_o),
        .pc_inc_o(pc_inc_o), .jmp_o(jmp_o), .bus_imm_o(bus_imm_o)
    );

    // R3 encodings
    localparam logic [5:0] D0 = 6'b000000, DA = 6'b000001, DM = 6'b000010, DP = 6'b000100,
                           DX = 6'b001000, DL = 6'b010000, DH = 6'b100000;
    localparam logic [4:0] L0 = 5'b00000, LA = 5'b00001, LM = 5'b00010, LX = 5'b00100,
                           LY = 5'b01000, LI = 5'b10000;
    localparam logic [5:0] A0 = 6'b000000, AADD = 6'b110010, AAND = 6'b110000,
                           AOR = 6'b111101, ANAND = 6'b110001, AM1 = 6'b000001,
                           AM2 = 6'b001110, AYM1 = 6'b011010;

    // {opcode, step, drv, load, alu, inc, jnz, jz}
    localparam int NENT = 27;
    localparam logic [30:0] TBL [NENT] = '{
        {8'd1, 3'd2, DL, LX, A0,    3'b000},
        {8'd2, 3'd2, DL, LY, A0,    3'b000},
        {8'd2, 3'd3, DA, LX, AADD,  3'b000},
        {8'd3, 3'd2, DH, LA, A0,    3'b000},
        {8'd3, 3'd3, DM, LX, A0,    3'b000},
        {8'd4, 3'd2, DH, LA, A0,    3'b000},
        {8'd4, 3'd3, DX, LM, A0,    3'b000},
        {8'd5, 3'd2, DA, LA, AM1,   3'b000},
        {8'd5, 3'd3, DM, LY, A0,    3'b000},
        {8'd5, 3'd4, DM, LA, A0,    3'b000},
        {8'd5, 3'd5, DX, LM, A0,    3'b000},
        {8'd5, 3'd6, DA, LA, AM1,   3'b000},
        {8'd5, 3'd7, DA, LM, AYM1,  3'b000},
        {8'd6, 3'd2, DA, LA, AM2,   3'b000},
        {8'd6, 3'd3, DA, LM, AOR,   3'b000},
        {8'd6, 3'd4, DA, LY, ANAND, 3'b000},
        {8'd6, 3'd5, DM, LX, A0,    3'b000},
        {8'd6, 3'd6, DA, LX, AAND,  3'b000},
        {8'd7, 3'd2, DH, LA, A0,    3'b000},
        {8'd7, 3'd3, DM, LX, A0,    3'b000},
        {8'd7, 3'd4, DP, LA, A0,    3'b000},
        {8'd7, 3'd5, DM, LY, A0,    3'b100},
        {8'd7, 3'd6, DA, L0, AAND,  3'b000},
        {8'd7, 3'd7, DP, L0, A0,    3'b110},
        {8'd8, 3'd2, DP, LA, A0,    3'b000},
        {8'd8, 3'd3, DM, L0, A0,    3'b110},
        {8'd9, 3'd2, DP, LA, A0,    3'b000}
    };

    localparam int NOPS = 12;
    localparam logic [7:0] OPS [NOPS] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
                                          8'h06, 8'h07, 8'h08, 8'h09, 8'h5A, 8'hFF};

    function automatic logic [30:0] lookup(input logic [7:0] op, input logic [2:0] s);
        logic [30:0] r = '0;
        for (int i = 0; i < NENT; i++)
            if (TBL[i][30:23] == op && TBL[i][22:20] == s) r = TBL[i];
        // JZ step 3 is added here: same shape as JNZ step 3 with the zero condition
        if (op == 8'd9 && s == 3'd3) r = {8'd9, 3'd3, DM, L0, A0, 3'b101};
        return r;
    endfunction

    function automatic string req_of(input logic [7:0] op, input logic [2:0] s);
        if (s < 3'd2) return "R2";
        if (op >= 8'd1 && op <= 8'd4) return "R7";
        if (op == 8'd5 || op == 8'd6) return "R8";
        if (op >= 8'd7 && op <= 8'd9) return "R9";
        return "R10";
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge with ir_i and flag_z_i already set.
    task automatic check_step(input logic [2:0] s);
        logic [30:0] e;
        logic [5:0]  ed;
        logic [4:0]  el;
        logic [5:0]  ea;
        logic        einc, ejmp;
        logic [15:0] eb;
        logic [7:0]  op;
        op = ir_i[15:8];
        e  = lookup(op, s);
        if (s == 3'd0)      begin ed = DP; el = LA; ea = A0; e[2:0] = 3'b000; end
        else if (s == 3'd1) begin ed = DM; el = LI; ea = A0; e[2:0] = 3'b000; end
        else                begin ed = e[19:14]; el = e[13:9]; ea = e[8:3]; end
        ejmp = (e[1] & ~flag_z_i) | (e[0] & flag_z_i);   // R6
        einc = e[2] & ~ejmp;
        if (ed == DH)      eb = {8'hFF, ir_i[7:0]};       // R4
        else if (ed == DL) eb = {8'h00, ir_i[7:0]};       // R5
        else               eb = 16'h0000;
        chk("R1", "step", 32'(step_o), 32'(s));
        chk(req_of(op, s), "ctrl", 32'({drv_o, load_o, alu_o}), 32'({ed, el, ea}));
        chk("R6", "jmp/inc", 32'({jmp_o, pc_inc_o}), 32'({ejmp, einc}));
        chk(ed == DH ? "R4" : "R5", "bus_imm", 32'(bus_imm_o), 32'(eb));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset step", 32'(step_o), 32'd0);
        rst = 1'b0;
        // Vector walk: every opcode, both flag values, all eight steps
        for (int fz = 0; fz < 2; fz++) begin
            for (int k = 0; k < NOPS; k++) begin
                ir_i     = {OPS[k], OPS[k] ^ 8'h3C};
                flag_z_i = fz[0];
                for (int s = 0; s < 8; s++) begin
                    check_step(3'(s));
                    @(posedge clk);
                    @(negedge clk);
                end
            end
        end
        // R1: reset in the middle of a push returns to fetch
        ir_i = {8'h05, 8'hA7};
        flag_z_i = 1'b0;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk("R1", "mid step before reset", 32'(step_o), 32'd3);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "step after mid reset", 32'(step_o), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R1", "step held in reset", 32'(step_o), 32'd0);
        rst = 1'b0;
        check_step(3'd0);
        @(posedge clk); @(negedge clk);
        check_step(3'd1);
        // R1: wrap from 7 back to 0
        for (int s = 2; s < 8; s++) begin
            @(posedge clk); @(negedge clk);
        end
        chk("R1", "step at 7", 32'(step_o), 32'd7);
        @(posedge clk); @(negedge clk);
        chk("R1", "wrap to 0", 32'(step_o), 32'd0);
        // R9/R6: skip test with immediate byte of all ones and zero flag set
        ir_i = {8'h07, 8'hFF};
        flag_z_i = 1'b1;
        for (int s = 0; s < 8; s++) begin
            check_step(3'(s));
            @(posedge clk); @(negedge clk);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule